// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This block settles every supported control transfer while the transfer instruction sits in the decode stage of a five-stage pipeline that has one architectural delay slot. The decode instruction word, the two source register values and the address that follows the instruction (the delay-slot address) go in. The block checks the branch condition and forms both possible targets. It then picks the address the fetch stage uses next: the sequential successor of the delay slot, the branch target or the jump target.

The block has no state, so the result is ready in the same cycle the instruction is decoded. The only instruction fetched after a branch or jump is its delay slot. Nothing has to be squashed and no fetch cycle is lost. The register values are taken as they arrive, and forwarding into the comparator is handled by other logic.

Top module: `idbr_resolve`

## Requirements
- R1: Opcode (instruction bits 31:26) 6'b000010, and 6'b000011 when the link-jump option is enabled, is an unconditional jump. taken_o is 1 and next_pc_o is {npc_i[31:28], instr_i[25:0], 2'b00}.
- R2: Opcode 6'b000100 is taken exactly when rs_val_i equals rt_val_i.
- R3: Opcode 6'b000101 is taken exactly when rs_val_i differs from rt_val_i.
- R4: Opcode 6'b000111 is taken exactly when rs_val_i is non-zero and its bit 31 is 0.
- R5: Opcode 6'b000001 is taken exactly when the rt field (bits 20:16) is 5'b00001 and bit 31 of rs_val_i is 0. Any other rt field value under this opcode is never taken.
- R6: A taken conditional branch gives next_pc_o = npc_i + (sign-extended instr_i[15:0] times 4), modulo 2^32. Negative offsets are included.
- R7: Any other instruction, and any branch that is not taken, gives taken_o = 0 and next_pc_o = npc_i + 4.
- R8: rt_val_i has no effect on the result of opcodes 6'b000111 and 6'b000001.
- R9: next_pc_o and taken_o are a combinational function of the current inputs, so the next fetch address is valid in the decode cycle itself with no penalty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word held in decode |
| rs_val_i | input | XLEN | Value of the first source register |
| rt_val_i | input | XLEN | Value of the second source register |
| npc_i | input | XLEN | Address that follows the decode instruction (delay-slot address) |
| next_pc_o | output | XLEN | Next fetch address |
| taken_o | output | 1 | Control is transferred away from the sequential path |

## Verification
Condition evaluation and target formation act in the same cycle. A wrong result can come from either one, or from the select that joins them. The sweep drives every supported opcode with every pairing of a set of edge operands (zero, one, all ones, the largest positive and most negative values) and with offsets that include the sign boundary. It also varies the delay-slot address, so some targets wrap past zero. The next address and the taken flag are judged against an arithmetic model of the expected target and condition. Rerunning the condition opcodes with different rt values shows that the unused operand has no effect.

// File: rtl/idbr_pkg.sv
package idbr_pkg;
   localparam int unsigned OPC_W  = 6;
   localparam int unsigned IMM_W  = 16;
   localparam int unsigned IDX_W  = 26;
   localparam int unsigned RSEL_W = 5;

   localparam logic [OPC_W-1:0] OPC_REGIMM = 6'b000001;
   localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;
   localparam logic [OPC_W-1:0] OPC_JLINK  = 6'b000011;
   localparam logic [OPC_W-1:0] OPC_EQ     = 6'b000100;
   localparam logic [OPC_W-1:0] OPC_NE     = 6'b000101;
   localparam logic [OPC_W-1:0] OPC_GTZ    = 6'b000111;
   localparam logic [RSEL_W-1:0] RT_GEZ    = 5'b00001;

   typedef enum logic [1:0] {
      PCSEL_SEQ = 2'd0,
      PCSEL_BR  = 2'd1,
      PCSEL_JMP = 2'd2
   } pc_sel_e;

   typedef struct packed {
      logic is_eq;
      logic is_ne;
      logic is_gtz;
      logic is_gez;
      logic is_jmp;
   } xfer_class_t;
endpackage

// File: rtl/idbr_decode.sv
module idbr_decode
   import idbr_pkg::*;
#(
   parameter bit JLINK_EN = 1'b1
) (
   input  logic [31:0]  instr_i,
   output xfer_class_t  cls_o
);
   logic [OPC_W-1:0]  opc;
   logic [RSEL_W-1:0] rt_field;
   logic              jlink_hit;

   assign opc      = instr_i[31:26];
   assign rt_field = instr_i[20:16];

   generate
      if (JLINK_EN) begin : g_jlink
         assign jlink_hit = (opc == OPC_JLINK);
      end else begin : g_nojlink
         assign jlink_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      cls_o        = '0;
      cls_o.is_eq  = (opc == OPC_EQ);
      cls_o.is_ne  = (opc == OPC_NE);
      cls_o.is_gtz = (opc == OPC_GTZ);
      cls_o.is_gez = (opc == OPC_REGIMM) && (rt_field == RT_GEZ);
      cls_o.is_jmp = (opc == OPC_JUMP) || jlink_hit;
   end

   // R5
   always_comb begin
      gez_field_chk: assert (!cls_o.is_gez || (instr_i[20:16] == 5'b00001))
         else $error("R5 greater-or-equal class without matching rt field");
   end

   // R1
   always_comb begin
      class_onehot_chk: assert ($onehot0(cls_o))
         else $error("R1 more than one transfer class decoded");
   end
endmodule

// File: rtl/idbr_cond.sv
module idbr_cond
   import idbr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  xfer_class_t       cls_i,
   input  logic [XLEN-1:0]   rs_val_i,
   input  logic [XLEN-1:0]   rt_val_i,
   output logic              br_taken_o
);
   localparam int unsigned SIGN_BIT = XLEN - 1;

   logic rs_zero;
   logic rs_neg;
   logic rs_eq_rt;

   assign rs_zero  = ~|rs_val_i;
   assign rs_neg   = rs_val_i[SIGN_BIT];
   assign rs_eq_rt = ~|(rs_val_i ^ rt_val_i);

   always_comb begin
      br_taken_o = (cls_i.is_eq  &  rs_eq_rt)
                 | (cls_i.is_ne  & ~rs_eq_rt)
                 | (cls_i.is_gtz & ~rs_zero & ~rs_neg)
                 | (cls_i.is_gez & ~rs_neg);
   end

   // R2
   always_comb begin
      eq_cond_chk: assert (!(cls_i.is_eq && br_taken_o) || (rs_val_i == rt_val_i))
         else $error("R2 equal branch taken on unequal operands");
   end

   // R4
   always_comb begin
      gtz_cond_chk: assert (!(cls_i.is_gtz && br_taken_o) || ($signed(rs_val_i) > 0))
         else $error("R4 greater-than-zero branch taken on non-positive value");
   end

   // R7
   always_comb begin
      idle_cond_chk: assert (($countones(cls_i) != 0) || !br_taken_o)
         else $error("R7 condition true without a branch class");
   end
endmodule

// File: rtl/idbr_target.sv
module idbr_target
   import idbr_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned WORD_SHIFT = 2
) (
   input  logic [31:0]      instr_i,
   input  logic [XLEN-1:0]  npc_i,
   output logic [XLEN-1:0]  seq_pc_o,
   output logic [XLEN-1:0]  br_pc_o,
   output logic [XLEN-1:0]  jmp_pc_o
);
   localparam int unsigned REGION_LSB = IDX_W + WORD_SHIFT;
   localparam int unsigned EXT_W      = XLEN - IMM_W - WORD_SHIFT;
   localparam logic [XLEN-1:0] STEP   = XLEN'(1) << WORD_SHIFT;

   logic [IMM_W-1:0] imm;
   logic [XLEN-1:0]  offset;

   assign imm    = instr_i[IMM_W-1:0];
   assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};

   assign seq_pc_o = npc_i + STEP;
   assign br_pc_o  = npc_i + offset;
   assign jmp_pc_o = {npc_i[XLEN-1:REGION_LSB], instr_i[IDX_W-1:0], {WORD_SHIFT{1'b0}}};

   // R1
   always_comb begin
      jmp_region_chk: assert (jmp_pc_o[XLEN-1:REGION_LSB] == npc_i[XLEN-1:REGION_LSB])
         else $error("R1 jump target left the current region");
   end

   // R6
   always_comb begin
      br_align_chk: assert (br_pc_o[WORD_SHIFT-1:0] == npc_i[WORD_SHIFT-1:0])
         else $error("R6 branch target alignment differs from base");
   end
endmodule

// File: rtl/idbr_resolve.sv
module idbr_resolve
   import idbr_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter bit          JLINK_EN = 1'b1
) (
   input  logic [31:0]      instr_i,
   input  logic [XLEN-1:0]  rs_val_i,
   input  logic [XLEN-1:0]  rt_val_i,
   input  logic [XLEN-1:0]  npc_i,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             taken_o
);
   localparam int unsigned WORD_SHIFT = 2;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("idbr_resolve: XLEN must be at least 32");
      end
   endgenerate

   xfer_class_t     cls;
   logic            br_taken;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;
   pc_sel_e         sel;

   idbr_decode #(.JLINK_EN(JLINK_EN)) decode_i (
      .instr_i (instr_i),
      .cls_o   (cls)
   );

   idbr_cond #(.XLEN(XLEN)) cond_i (
      .cls_i      (cls),
      .rs_val_i   (rs_val_i),
      .rt_val_i   (rt_val_i),
      .br_taken_o (br_taken)
   );

   idbr_target #(.XLEN(XLEN), .WORD_SHIFT(WORD_SHIFT)) target_i (
      .instr_i  (instr_i),
      .npc_i    (npc_i),
      .seq_pc_o (seq_pc),
      .br_pc_o  (br_pc),
      .jmp_pc_o (jmp_pc)
   );

   always_comb begin
      if (cls.is_jmp)      sel = PCSEL_JMP;
      else if (br_taken)   sel = PCSEL_BR;
      else                 sel = PCSEL_SEQ;
   end

   always_comb begin
      case (sel)
         PCSEL_JMP: next_pc_o = jmp_pc;
         PCSEL_BR:  next_pc_o = br_pc;
         default:   next_pc_o = seq_pc;
      endcase
   end

   assign taken_o = (sel != PCSEL_SEQ);

   // R7
   always_comb begin
      seq_path_chk: assert (taken_o || (next_pc_o == npc_i + (XLEN'(1) << WORD_SHIFT)))
         else $error("R7 untaken result is not the sequential address");
   end

   // R1
   always_comb begin
      jump_taken_chk: assert (!cls.is_jmp || taken_o)
         else $error("R1 jump not reported as taken");
   end
endmodule

// File: tb/idbr_resolve_tb.sv
module idbr_resolve_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr, rs_v, rt_v, npc;
   logic [31:0] next_pc;
   logic        taken;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #10 clk = ~clk;

   idbr_resolve #(.XLEN(32), .JLINK_EN(1'b1)) dut_i (
      .instr_i   (instr),
      .rs_val_i  (rs_v),
      .rt_val_i  (rt_v),
      .npc_i     (npc),
      .next_pc_o (next_pc),
      .taken_o   (taken)
   );

   function automatic void model(input logic [31:0] ins, input logic [31:0] a,
                                 input logic [31:0] b, input logic [31:0] pc,
                                 output logic [31:0] exp_pc, output bit exp_tk,
                                 output string tag);
      logic [5:0]  op   = ins[31:26];
      logic [31:0] seqa = pc + 32'd4;
      int          soff = $signed(ins[15:0]) * 4;
      logic [31:0] bra  = pc + 32'(soff);
      logic [31:0] jma  = (pc & 32'hF000_0000) | ({6'd0, ins[25:0]} * 32'd4);
      bit          cnd  = 1'b0;
      bit          isbr = 1'b1;
      case (op)
         6'b000010, 6'b000011: begin exp_pc = jma; exp_tk = 1'b1; tag = "R1 R9"; return; end
         6'b000100: begin cnd = (a == b); tag = "R2 R6"; end
         6'b000101: begin cnd = (a != b); tag = "R3 R6"; end
         6'b000111: begin cnd = ($signed(a) > 0); tag = "R4 R8 R6"; end
         6'b000001: begin cnd = (ins[20:16] == 5'd1) && !a[31]; tag = "R5 R8 R6"; end
         default:   begin isbr = 1'b0; tag = "R7"; end
      endcase
      exp_tk = isbr && cnd;
      exp_pc = exp_tk ? bra : seqa;
      if (!exp_tk) tag = {tag, " R7"};
   endfunction

   task automatic apply(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] pc);
      logic [31:0] e_pc;
      bit          e_tk;
      string       tag;
      @(negedge clk);
      instr = ins; rs_v = a; rt_v = b; npc = pc;
      model(ins, a, b, pc, e_pc, e_tk, tag);
      #2;
      n_chk++;
      if (next_pc !== e_pc || taken !== e_tk) begin
         n_bad++;
         $display("FAIL %s ins=%h rs=%h rt=%h npc=%h: next_pc=%h taken=%0b expected next_pc=%h taken=%0b",
                  tag, ins, a, b, pc, next_pc, taken, e_pc, e_tk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: finished=0 expected finished=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] vals [6];
      logic [15:0] offs [6];
      logic [31:0] pcs  [4];
      logic [5:0]  ops  [10];
      vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};
      offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'hFFFD};
      pcs  = '{32'h0000_1004, 32'h0000_0008, 32'hFFFF_FFF8, 32'h8ABC_0100};
      ops  = '{6'b000000, 6'b000001, 6'b000010, 6'b000011, 6'b000100,
               6'b000101, 6'b000110, 6'b000111, 6'b001000, 6'b111111};
      instr = '0; rs_v = '0; rt_v = '0; npc = 32'h0000_0100;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-time idle word: R7 sequential path
      apply(32'h0000_0000, 32'h0, 32'h0, 32'h0000_0100);
      // explicit R8 pair: rt value changes, result must not
      apply({6'b000111, 5'd3, 5'd9, 16'hFFF0}, 32'h5, 32'h0, 32'h2000);
      apply({6'b000111, 5'd3, 5'd9, 16'hFFF0}, 32'h5, 32'hFFFF_FFFF, 32'h2000);
      for (int o = 0; o < 10; o++)
         for (int r = 0; r < 4; r++)
            for (int i = 0; i < 6; i++)
               for (int j = 0; j < 6; j++)
                  for (int k = 0; k < 6; k++)
                     apply({ops[o], 5'h0A, 5'(r), offs[k]}, vals[i], vals[j],
                           pcs[(i + j + k) % 4]);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule